// File: doc/BRIEF.md
# Overtemperature Mode Supervisor

This block watches the thermal-shutdown comparator of a system basis chip and takes the chip into its Overtemp mode when the die runs too hot. The comparator output arrives asynchronously. It goes through a two-flop synchronizer and then a debounce filter: the synchronized level must differ from the filtered level for `DEB_CYCLES` consecutive clocks before the filtered level changes. The filtered flag only counts while the chip's current mode is Standby or Normal.

The state machine has three states: `ST_WATCH` (monitoring, software requests pass through), `ST_HOT` (Overtemp forced) and `ST_LEAVE` (a single cycle that requests Standby). It has four transitions:
- *heat-trip*: `ST_WATCH` to `ST_HOT`, when the filtered flag is high in a monitored mode.
- *cool-down*: `ST_HOT` to `ST_LEAVE`, when the filtered flag falls.
- *settle*: `ST_LEAVE` to `ST_WATCH`, unconditional.
- *stay*: every other case holds the state.

While the machine is in `ST_HOT`, the block drives four controls together: the reset pin goes low, limp-home turns on, and the regulators and the CAN transmitter are switched off. After the chip leaves Overtemp, limp-home stays latched until software clears it.

Top module: `thermal_guard_top`

Mode encoding (on `cur_mode`, `sw_req_mode` and `req_mode`): 00 Standby, 01 Normal, 10 Sleep, 11 Overtemp/reserved.

## Requirements
- R1: After reset, `ot_mode`=0, `rst_pin_n`=1, `limp_on`=0, `reg_off`=0, `tx_off`=0, and `req_valid` follows only `sw_req_valid`.
- R2: The raw flag goes through two synchronizer flops and a filter of `DEB_CYCLES` cycles. With the default `DEB_CYCLES`=4, a level change on `temp_hot_raw` (driven between clock edges, in a monitored mode) shows on the outputs after the 7th rising edge and not after the 6th. A pulse held for `DEB_CYCLES` clocks is acted on. A pulse held for `DEB_CYCLES`-1 clocks is ignored.
- R3: A high filtered flag starts Overtemp only while `cur_mode` is 00 (Standby) or 01 (Normal). In modes 10 and 11 it has no effect. If the flag is still high when the mode becomes monitored, Overtemp starts on the next edge.
- R4: In Overtemp, `ot_mode`=1, `rst_pin_n`=0 and `limp_on`=1. `cur_mode` is ignored there.
- R5: In Overtemp, `reg_off`=1 and `tx_off`=1. All four forced controls change in the same cycle.
- R6: When the filtered flag falls in Overtemp, the block spends exactly one cycle with `req_valid`=1 and `req_mode`=00 (Standby), with the forced controls released. It then returns to monitoring.
- R7: `limp_on` stays 1 after Overtemp ends. A one-cycle `limp_clr` outside Overtemp drops it one edge later. `limp_clr` during Overtemp is ignored.
- R8: While monitoring, `req_valid`/`req_mode` equal `sw_req_valid`/`sw_req_mode` combinationally. In Overtemp, `req_valid`=0 whatever software requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| temp_hot_raw | input | 1 | Asynchronous over-threshold comparator flag |
| cur_mode | input | 2 | Current operating mode of the chip |
| sw_req_valid | input | 1 | Software mode-change request strobe |
| sw_req_mode | input | 2 | Mode requested by software |
| limp_clr | input | 1 | Software clear of the limp-home latch |
| req_valid | output | 1 | Mode-transition request to the mode controller |
| req_mode | output | 2 | Requested mode |
| ot_mode | output | 1 | High while Overtemp is forced |
| rst_pin_n | output | 1 | Reset pin drive, low in Overtemp |
| limp_on | output | 1 | Limp-home activation |
| reg_off | output | 1 | Voltage regulator disable |
| tx_off | output | 1 | CAN transmitter disable |

## Verification
The assertions assume that `cur_mode` and the software request inputs are synchronous to `clk` and settle between edges, and that `limp_clr` is a strobe rather than a level. Only the thermal flag may be asynchronous. The bench changes every input on the falling edge and holds each thermal level for at least `DEB_CYCLES` clocks, except in the deliberate short-glitch case. It pulses `limp_clr` and the software request for single cycles.

// File: rtl/thermal_guard_pkg.sv
package thermal_guard_pkg;

    typedef enum logic [1:0] {
        MODE_STANDBY  = 2'b00,
        MODE_NORMAL   = 2'b01,
        MODE_SLEEP    = 2'b10,
        MODE_OVERTEMP = 2'b11
    } op_mode_e;

    typedef enum logic [1:0] {
        ST_WATCH = 2'b00,
        ST_HOT   = 2'b01,
        ST_LEAVE = 2'b10
    } guard_state_e;

    function automatic logic mode_is_watched(input logic [1:0] m);
        return (m == MODE_STANDBY) || (m == MODE_NORMAL);
    endfunction

endpackage

// File: rtl/thermal_flag_filter.sv
module thermal_flag_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int DEB_CYCLES  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic flag_out
);
    localparam int CNT_W = (DEB_CYCLES < 2) ? 1 : $clog2(DEB_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_CYCLES - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   synced;
    logic [CNT_W-1:0]       cnt_q;
    logic                   filt_q;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= raw_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[i] <= 1'b0;
                    else        sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    assign synced = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            filt_q <= 1'b0;
        end else if (synced == filt_q) begin
            cnt_q <= '0;
        end else if (cnt_q == CNT_LAST) begin
            cnt_q  <= '0;
            filt_q <= synced;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign flag_out = filt_q;

endmodule

// File: rtl/thermal_guard_fsm.sv
module thermal_guard_fsm
    import thermal_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hot_flag,
    input  logic [1:0] cur_mode,
    input  logic       sw_req_valid,
    input  logic [1:0] sw_req_mode,
    output logic       in_hot,
    output logic       req_valid,
    output logic [1:0] req_mode,
    output logic       rst_pin_n,
    output logic       reg_off,
    output logic       tx_off
);
    guard_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WATCH;
        else        state_q <= state_d;
    end

    // transitions: heat-trip, cool-down, settle, stay
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WATCH: if (hot_flag && mode_is_watched(cur_mode)) state_d = ST_HOT;
            ST_HOT:   if (!hot_flag) state_d = ST_LEAVE;
            ST_LEAVE: state_d = ST_WATCH;
            default:  state_d = ST_WATCH;
        endcase
    end

    // outputs
    always_comb begin
        in_hot    = 1'b0;
        rst_pin_n = 1'b1;
        reg_off   = 1'b0;
        tx_off    = 1'b0;
        req_valid = 1'b0;
        req_mode  = MODE_STANDBY;
        unique case (state_q)
            ST_WATCH: begin
                req_valid = sw_req_valid;
                req_mode  = sw_req_mode;
            end
            ST_HOT: begin
                in_hot    = 1'b1;
                rst_pin_n = 1'b0;
                reg_off   = 1'b1;
                tx_off    = 1'b1;
            end
            ST_LEAVE: begin
                req_valid = 1'b1;
                req_mode  = MODE_STANDBY;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/limp_home_latch.sv
module limp_home_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic force_on,
    input  logic clr,
    output logic limp_on
);
    logic held_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        held_q <= 1'b0;
        else if (force_on) held_q <= 1'b1;
        else if (clr)      held_q <= 1'b0;
    end

    assign limp_on = held_q | force_on;

endmodule

// File: rtl/thermal_guard_top.sv
module thermal_guard_top #(
    parameter int SYNC_STAGES = 2,
    parameter int DEB_CYCLES  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       temp_hot_raw,
    input  logic [1:0] cur_mode,
    input  logic       sw_req_valid,
    input  logic [1:0] sw_req_mode,
    input  logic       limp_clr,
    output logic       req_valid,
    output logic [1:0] req_mode,
    output logic       ot_mode,
    output logic       rst_pin_n,
    output logic       limp_on,
    output logic       reg_off,
    output logic       tx_off
);
    logic hot_filt;
    logic hot_state;

    thermal_flag_filter #(
        .SYNC_STAGES(SYNC_STAGES),
        .DEB_CYCLES (DEB_CYCLES)
    ) filt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_in  (temp_hot_raw),
        .flag_out(hot_filt)
    );

    thermal_guard_fsm fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .hot_flag    (hot_filt),
        .cur_mode    (cur_mode),
        .sw_req_valid(sw_req_valid),
        .sw_req_mode (sw_req_mode),
        .in_hot      (hot_state),
        .req_valid   (req_valid),
        .req_mode    (req_mode),
        .rst_pin_n   (rst_pin_n),
        .reg_off     (reg_off),
        .tx_off      (tx_off)
    );

    limp_home_latch limp_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .force_on(hot_state),
        .clr     (limp_clr),
        .limp_on (limp_on)
    );

    assign ot_mode = hot_state;

endmodule

// File: rtl/thermal_guard_chk.sv
module thermal_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cur_mode,
    input logic       limp_clr,
    input logic       req_valid,
    input logic [1:0] req_mode,
    input logic       ot_mode,
    input logic       rst_pin_n,
    input logic       limp_on,
    input logic       reg_off,
    input logic       tx_off
);
    AST_FORCED_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        reg_off |-> (!rst_pin_n && tx_off && limp_on)); // R5

    AST_NO_REQ_WHEN_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        ot_mode |-> !req_valid); // R8

    AST_EXIT_TO_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ot_mode) |-> (req_valid && req_mode == 2'b00 && rst_pin_n)); // R6

    AST_LIMP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (limp_on && !limp_clr) |=> limp_on); // R7

    AST_ENTRY_MONITORED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ot_mode) |-> ($past(cur_mode) == 2'b00 || $past(cur_mode) == 2'b01)); // R3

endmodule

bind thermal_guard_top thermal_guard_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cur_mode (cur_mode),
    .limp_clr (limp_clr),
    .req_valid(req_valid),
    .req_mode (req_mode),
    .ot_mode  (ot_mode),
    .rst_pin_n(rst_pin_n),
    .limp_on  (limp_on),
    .reg_off  (reg_off),
    .tx_off   (tx_off)
);

// File: tb/thermal_guard_top_tb_top.sv
module thermal_guard_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       temp_hot_raw = 1'b0;
    logic [1:0] cur_mode = 2'b01;
    logic       sw_req_valid = 1'b0;
    logic [1:0] sw_req_mode = 2'b00;
    logic       limp_clr = 1'b0;
    logic       req_valid, ot_mode, rst_pin_n, limp_on, reg_off, tx_off;
    logic [1:0] req_mode;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    thermal_guard_top #(.SYNC_STAGES(2), .DEB_CYCLES(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .temp_hot_raw(temp_hot_raw), .cur_mode(cur_mode),
        .sw_req_valid(sw_req_valid), .sw_req_mode(sw_req_mode), .limp_clr(limp_clr),
        .req_valid(req_valid), .req_mode(req_mode), .ot_mode(ot_mode),
        .rst_pin_n(rst_pin_n), .limp_on(limp_on), .reg_off(reg_off), .tx_off(tx_off)
    );

    // {mode[1:0], raw, cycles[7:0], exp_ot, exp_limp}
    localparam logic [12:0] VEC [7] = '{
        {2'b01, 1'b0, 8'd10, 1'b0, 1'b0},  // R1 quiet in Normal
        {2'b10, 1'b1, 8'd12, 1'b0, 1'b0},  // R3 Sleep not watched
        {2'b11, 1'b1, 8'd12, 1'b0, 1'b0},  // R3 mode 11 not watched
        {2'b00, 1'b1, 8'd12, 1'b1, 1'b1},  // R3 R4 Standby trips
        {2'b01, 1'b1, 8'd12, 1'b1, 1'b1},  // R4 mode ignored in Overtemp
        {2'b01, 1'b0, 8'd12, 1'b0, 1'b1},  // R7 limp held after exit
        {2'b10, 1'b0, 8'd12, 1'b0, 1'b1}   // R7 still held
    };

    // {ot, rst_pin_n, limp, reg_off, tx_off}
    task automatic chk5(input string tag, input logic [4:0] exp);
        logic [4:0] act;
        act = {ot_mode, rst_pin_n, limp_on, reg_off, tx_off};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%b exp=%b", tag, act, exp);
        end
    endtask

    task automatic chkreq(input string tag, input logic v, input logic [1:0] m);
        checks++;
        if (req_valid !== v || (v && req_mode !== m)) begin
            errors++;
            $display("FAIL %s act=%b/%b exp=%b/%b", tag, req_valid, req_mode, v, m);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        ticks(3);
        chk5("R1 reset", 5'b01000);
        chkreq("R1 reset request", 1'b0, 2'b00);
        rst_n = 1'b1;
        ticks(2);
        chk5("R1 after release", 5'b01000);

        for (int k = 0; k < 7; k++) begin
            cur_mode     = VEC[k][12:11];
            temp_hot_raw = VEC[k][10];
            ticks(int'(VEC[k][9:2]));
            chk5($sformatf("R3/R4/R5/R7 row %0d", k),
                 {VEC[k][1], ~VEC[k][1], VEC[k][0], VEC[k][1], VEC[k][1]});
        end

        // R7 clear outside Overtemp
        limp_clr = 1'b1; ticks(1); limp_clr = 1'b0;
        chk5("R7 limp cleared", 5'b01000);

        // R8 pass-through while watching
        cur_mode = 2'b01;
        sw_req_valid = 1'b1; sw_req_mode = 2'b10; #1;
        chkreq("R8 pass-through", 1'b1, 2'b10);
        sw_req_valid = 1'b0;

        // R2 latency: 6 edges not yet, 7th edge in Overtemp
        temp_hot_raw = 1'b1;
        ticks(6);
        chk5("R2 not after 6 edges", 5'b01000);
        ticks(1);
        chk5("R2 R5 after 7 edges", 5'b10111);

        // R8 blocked in Overtemp; R7 clear ignored in Overtemp
        sw_req_valid = 1'b1; sw_req_mode = 2'b01; #1;
        chkreq("R8 blocked in Overtemp", 1'b0, 2'b00);
        sw_req_valid = 1'b0;
        limp_clr = 1'b1; ticks(1); limp_clr = 1'b0;

        // R6 exit: one Standby request cycle
        temp_hot_raw = 1'b0;
        ticks(6);
        chk5("R6 still hot after 6 edges", 5'b10111);
        ticks(1);
        chk5("R6 released on exit", 5'b01100);
        chkreq("R6 standby request", 1'b1, 2'b00);
        ticks(1);
        chkreq("R6 request one cycle", 1'b0, 2'b00);
        chk5("R7 clear in Overtemp ignored", 5'b01100);
        limp_clr = 1'b1; ticks(1); limp_clr = 1'b0;

        // R2 glitch of DEB-1 cycles ignored
        temp_hot_raw = 1'b1; ticks(3); temp_hot_raw = 1'b0;
        ticks(12);
        chk5("R2 short glitch ignored", 5'b01000);

        // R2 pulse of DEB cycles acted on
        temp_hot_raw = 1'b1; ticks(4); temp_hot_raw = 1'b0;
        ticks(3);
        chk5("R2 DEB pulse trips", 5'b10111);
        ticks(20);
        chk5("R2 DEB pulse exits", 5'b01100);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule